// File: doc/BRIEF.md
# External Transfer-Request Decoder with Per-Channel Queues

This block sits between an external requester and a four-channel DMA controller. The requester drives one 7-bit command word per cycle, marked by a valid strobe. The block decodes each word into one of five outcomes:

- a queued request for channel 1, 2 or 3;
- a handshake request for channel 0;
- a stop command that clears the channel-0 enable;
- a flush of every pending request;
- a no-operation.

Channels 1 to 3 each get a shallow request queue. A queue holds only a count, because a request carries no payload. Each queue offers its channel engine a valid/ready pop interface. Channel 0 has a single pending flag that its engine clears with a take strobe. Whether a channel-0 request or a stop command is accepted depends on the channel-0 busy input.

The channel-0 enable bit is held here. The local processor can set it through a dedicated strobe. An external stop command can only clear it.

A flush empties the queues, drops the channel-0 pending flag, and emits a one-cycle pulse that tells the controller to drop its own held requests. When the freeze-recovery mode input is high at the moment the flush is accepted, the block also emits a freeze-clear pulse.

Top module: `xfer_req_decoder`

## Requirements
- R1: The command word is `{id[6:5], md[4:3], sz[2:0]}`. When `cmd_valid` is high and `id` is nonzero, one request is pushed into the queue of channel `id`, for `id` values 1, 2 and 3. The `md` and `sz` fields have no effect in this case.
- R2: Each queue holds up to QDEPTH requests, with a default of 4. A push to a full queue that is not popping in the same cycle is discarded. `q_valid[n-1]` is high while channel n's queue is non-empty. A pop occurs when both `q_valid` and `q_ready` are high for that channel, and removes one entry at the clock edge.
- R3: A push and a pop on the same full queue in the same cycle both succeed, so the queue stays full.
- R4: A word with `id=00`, `md=00` and `sz` not equal to 101 or 110 is a channel-0 handshake request. When `ch0_busy` is low it sets `ch0_req` in the next cycle. When `ch0_busy` is high it is ignored.
- R5: `ch0_take` clears `ch0_req` in the next cycle. An accepted channel-0 request in the same cycle wins, and `ch0_req` stays high.
- R6: A word with `id=00`, `md` not equal to 00 and `sz=111` is a stop command. When `ch0_busy` is low it clears `ch0_en` in the next cycle. When `ch0_busy` is high it is refused, and `ch0_en` is unchanged.
- R7: `cpu_en_set` sets `ch0_en` in the next cycle, and overrides a stop command in the same cycle. No command word can set `ch0_en`.
- R8: A word with `id=00`, `md=10` and `sz=110` is a flush. It is accepted regardless of `ch0_busy`. In the next cycle:
  - all `q_valid` bits are low;
  - `ch0_req` is low;
  - `flush_pulse` is high for one cycle.

  The flush overrides any pop or take that arrives in the same cycle.
- R9: `freeze_clr` is high in the cycle after an accepted flush exactly when `freeze_recover` was high in the flush cycle. Otherwise it is low.
- R10: Any other word with `id=00` is a no-operation and changes no output. This covers `md=00` with `sz=101` or `sz=110`, and every word with `md` not equal to 00 that is neither a stop nor a flush.
- R11: During and after reset, every output is low, and all queues are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word present this cycle |
| cmd_word | input | 7 | Command word `{id, md, sz}` |
| ch0_busy | input | 1 | Channel-0 bus cycle or transfer in progress |
| ch0_take | input | 1 | Channel-0 engine consumes the pending request |
| cpu_en_set | input | 1 | Local processor write that sets the channel-0 enable |
| freeze_recover | input | 1 | Freeze-recovery mode bit |
| q_ready | input | 3 | Pop ready per channel 1..3 (bit n-1 for channel n) |
| q_valid | output | 3 | Queue non-empty per channel 1..3 |
| ch0_req | output | 1 | Channel-0 request pending |
| ch0_en | output | 1 | Channel-0 enable bit |
| flush_pulse | output | 1 | Drop held external requests |
| freeze_clr | output | 1 | Clear controller freeze state |

## Verification
The bench builds the block with its default QDEPTH of 4, so filling a queue takes only four pushes. The overflow discard and the simultaneous push-and-pop on a full queue are therefore both reached within a few directed cycles on each channel. A behavioural model, counting integers per channel, is compared against all outputs on every cycle. It runs through directed sequences for every word class against both busy states, then through a long stretch of random words, ready patterns and strobes. The random stretch mixes flushes with pops and takes, in the same cycle and in the cycles around them.

// File: rtl/xrq_pkg.sv
package xrq_pkg;
  localparam int ID_W   = 2;
  localparam int MD_W   = 2;
  localparam int SZ_W   = 3;
  localparam int WORD_W = ID_W + MD_W + SZ_W;
  localparam int NUM_Q  = (1 << ID_W) - 1;

  typedef enum logic [2:0] {
    ACT_NOP,
    ACT_QUEUE,
    ACT_HS,
    ACT_STOP,
    ACT_FLUSH
  } act_e;

  // Classifies one command word; flush is tested before stop because both have md != 0.
  function automatic act_e classify(logic [WORD_W-1:0] w);
    logic [ID_W-1:0] id;
    logic [MD_W-1:0] md;
    logic [SZ_W-1:0] sz;
    id = w[WORD_W-1 -: ID_W];
    md = w[SZ_W +: MD_W];
    sz = w[SZ_W-1:0];
    if (id != '0) return ACT_QUEUE;
    if (md == 2'b10 && sz == 3'b110) return ACT_FLUSH;
    if (md != '0 && sz == 3'b111) return ACT_STOP;
    if (md == '0 && sz != 3'b101 && sz != 3'b110) return ACT_HS;
    return ACT_NOP;
  endfunction

  function automatic logic [ID_W-1:0] word_id(logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: ID_W];
  endfunction
endpackage

// File: rtl/xrq_decode.sv
module xrq_decode
  import xrq_pkg::*;
(
  input  logic              cmd_valid,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              ch0_busy,
  output logic [NUM_Q-1:0]  push_req,
  output logic              hs_acc,
  output logic              stop_req,
  output logic              flush_acc
);
  act_e            act;
  logic [ID_W-1:0] id;

  assign act = classify(cmd_word);
  assign id  = word_id(cmd_word);

  assign hs_acc    = cmd_valid && (act == ACT_HS) && !ch0_busy;
  assign stop_req  = cmd_valid && (act == ACT_STOP) && !ch0_busy;
  assign flush_acc = cmd_valid && (act == ACT_FLUSH);

  for (genvar i = 0; i < NUM_Q; i++) begin : g_sel
    assign push_req[i] = cmd_valid && (act == ACT_QUEUE) && (id == ID_W'(i + 1));
  end
endmodule

// File: rtl/xrq_count_q.sv
module xrq_count_q #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic ready,
  input  logic flush,
  output logic valid,
  output logic push_acc
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt, cnt_nxt;
  logic          pop_acc;

  assign valid    = (cnt != '0);
  assign pop_acc  = valid && ready && !flush;
  assign push_acc = push && !flush && ((cnt < CW'(DEPTH)) || pop_acc);

  always_comb begin
    cnt_nxt = cnt;
    if (flush)                    cnt_nxt = '0;
    else if (push_acc && !pop_acc) cnt_nxt = cnt + CW'(1);
    else if (!push_acc && pop_acc) cnt_nxt = cnt - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/xrq_ch0_ctrl.sv
module xrq_ch0_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_acc,
  input  logic stop_req,
  input  logic flush_acc,
  input  logic take,
  input  logic cpu_set,
  input  logic freeze_mode,
  output logic pend,
  output logic en,
  output logic fpulse,
  output logic fclr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      en     <= 1'b0;
      fpulse <= 1'b0;
      fclr   <= 1'b0;
    end else begin
      if (flush_acc)   pend <= 1'b0;
      else if (hs_acc) pend <= 1'b1;
      else if (take)   pend <= 1'b0;
      if (cpu_set)       en <= 1'b1;
      else if (stop_req) en <= 1'b0;
      fpulse <= flush_acc;
      fclr   <= flush_acc && freeze_mode;
    end
  end
endmodule

// File: rtl/xfer_req_decoder.sv
module xfer_req_decoder
  import xrq_pkg::*;
#(
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              ch0_busy,
  input  logic              ch0_take,
  input  logic              cpu_en_set,
  input  logic              freeze_recover,
  input  logic [NUM_Q-1:0]  q_ready,
  output logic [NUM_Q-1:0]  q_valid,
  output logic              ch0_req,
  output logic              ch0_en,
  output logic              flush_pulse,
  output logic              freeze_clr
);
  // Internal events, named so the checker can observe them.
  logic [NUM_Q-1:0] push_req;
  logic [NUM_Q-1:0] push_acc;
  logic             hs_acc;
  logic             stop_req;
  logic             flush_acc;

  xrq_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .ch0_busy  (ch0_busy),
    .push_req  (push_req),
    .hs_acc    (hs_acc),
    .stop_req  (stop_req),
    .flush_acc (flush_acc)
  );

  for (genvar i = 0; i < NUM_Q; i++) begin : g_q
    xrq_count_q #(.DEPTH(QDEPTH)) u_q (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push_req[i]),
      .ready    (q_ready[i]),
      .flush    (flush_acc),
      .valid    (q_valid[i]),
      .push_acc (push_acc[i])
    );
  end

  xrq_ch0_ctrl u_ch0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .hs_acc      (hs_acc),
    .stop_req    (stop_req),
    .flush_acc   (flush_acc),
    .take        (ch0_take),
    .cpu_set     (cpu_en_set),
    .freeze_mode (freeze_recover),
    .pend        (ch0_req),
    .en          (ch0_en),
    .fpulse      (flush_pulse),
    .fclr        (freeze_clr)
  );
endmodule

// File: rtl/xrq_checker.sv
module xrq_checker
  import xrq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [WORD_W-1:0] cmd_word,
  input logic              ch0_busy,
  input logic              cpu_en_set,
  input logic              freeze_recover,
  input logic [NUM_Q-1:0]  q_valid,
  input logic              ch0_req,
  input logic              ch0_en,
  input logic              flush_pulse,
  input logic              freeze_clr,
  input logic [NUM_Q-1:0]  push_acc,
  input logic              hs_acc,
  input logic              flush_acc
);
  act_e act;
  assign act = classify(cmd_word);

  for (genvar i = 0; i < NUM_Q; i++) begin : g_chk
    // R1: an accepted push leaves the queue non-empty in the next cycle
    assert_push_fills_R1: assert property (@(posedge clk) disable iff (!rst_n)
      push_acc[i] |=> q_valid[i]);
  end

  assert_hs_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hs_acc |=> ch0_req);

  assert_busy_hs_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && act == ACT_HS && ch0_busy && !ch0_req) |=> !ch0_req);

  assert_stop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && act == ACT_STOP && !ch0_busy && !cpu_en_set) |=> !ch0_en);

  assert_stop_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && act == ACT_STOP && ch0_busy && ch0_en) |=> ch0_en);

  assert_cpu_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_en_set |=> ch0_en);

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_acc |=> (q_valid == '0 && !ch0_req && flush_pulse));

  assert_no_freeze_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_acc && !freeze_recover) |=> !freeze_clr);

  assert_freeze_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_acc && freeze_recover) |=> freeze_clr);
endmodule

bind xfer_req_decoder xrq_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmd_valid      (cmd_valid),
  .cmd_word       (cmd_word),
  .ch0_busy       (ch0_busy),
  .cpu_en_set     (cpu_en_set),
  .freeze_recover (freeze_recover),
  .q_valid        (q_valid),
  .ch0_req        (ch0_req),
  .ch0_en         (ch0_en),
  .flush_pulse    (flush_pulse),
  .freeze_clr     (freeze_clr),
  .push_acc       (push_acc),
  .hs_acc         (hs_acc),
  .flush_acc      (flush_acc)
);

// File: tb/xfer_req_decoder_tb.sv
`timescale 1ns/1ps
module xfer_req_decoder_tb_top;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [6:0] cmd_word = '0;
  logic       ch0_busy = 1'b0;
  logic       ch0_take = 1'b0;
  logic       cpu_en_set = 1'b0;
  logic       freeze_recover = 1'b0;
  logic [2:0] q_ready = '0;
  logic [2:0] q_valid;
  logic       ch0_req, ch0_en, flush_pulse, freeze_clr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Reference state
  int m_cnt [3];
  bit m_pend, m_en, m_fp, m_fc;

  always #2 clk = ~clk;

  xfer_req_decoder #(.QDEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .ch0_busy(ch0_busy), .ch0_take(ch0_take), .cpu_en_set(cpu_en_set),
    .freeze_recover(freeze_recover), .q_ready(q_ready), .q_valid(q_valid),
    .ch0_req(ch0_req), .ch0_en(ch0_en), .flush_pulse(flush_pulse),
    .freeze_clr(freeze_clr)
  );

  function automatic logic [6:0] mk(int id, int md, int sz);
    return {id[1:0], md[1:0], sz[2:0]};
  endfunction

  // Word kind: 0 nop, 1 queue, 2 handshake, 3 stop, 4 flush
  function automatic int kind(logic [6:0] w);
    int id = int'(w[6:5]);
    int md = int'(w[4:3]);
    int sz = int'(w[2:0]);
    if (id > 0) return 1;
    case (md)
      0:       return (sz == 5 || sz == 6) ? 0 : 2;
      2:       return (sz == 6) ? 4 : (sz == 7 ? 3 : 0);
      default: return (sz == 7) ? 3 : 0;
    endcase
  endfunction

  task automatic model_step();
    int  k  = cmd_valid ? kind(cmd_word) : -1;
    bit  fl = (k == 4);
    for (int i = 0; i < 3; i++) begin
      bit pop = q_ready[i] && m_cnt[i] > 0 && !fl;
      bit psh = (k == 1) && int'(cmd_word[6:5]) == i + 1 && !fl && (m_cnt[i] < DEPTH || pop);
      if (fl) m_cnt[i] = 0;
      else    m_cnt[i] = m_cnt[i] + int'(psh) - int'(pop);
    end
    if (fl)                          m_pend = 0;
    else if (k == 2 && !ch0_busy)    m_pend = 1;
    else if (ch0_take)               m_pend = 0;
    if (cpu_en_set)                  m_en = 1;
    else if (k == 3 && !ch0_busy)    m_en = 0;
    m_fp = fl;
    m_fc = fl && freeze_recover;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    for (int i = 0; i < 3; i++)
      chk(q_valid[i] == (m_cnt[i] > 0), {tag, " R1 R2 R3 queue valid"}, int'(q_valid[i]), int'(m_cnt[i] > 0));
    chk(ch0_req == m_pend, {tag, " R4 R5 ch0_req"}, int'(ch0_req), int'(m_pend));
    chk(ch0_en == m_en, {tag, " R6 R7 ch0_en"}, int'(ch0_en), int'(m_en));
    chk(flush_pulse == m_fp, {tag, " R8 flush_pulse"}, int'(flush_pulse), int'(m_fp));
    chk(freeze_clr == m_fc, {tag, " R9 freeze_clr"}, int'(freeze_clr), int'(m_fc));
  endtask

  task automatic step(bit v, logic [6:0] w, bit busy, bit take, bit set, bit frm,
                      logic [2:0] rdy, string tag);
    cmd_valid = v; cmd_word = w; ch0_busy = busy; ch0_take = take;
    cpu_en_set = set; freeze_recover = frm; q_ready = rdy;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(int n, logic [2:0] rdy, string tag);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, 0, rdy, tag);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) m_cnt[i] = 0;
    m_pend = 0; m_en = 0; m_fp = 0; m_fc = 0;
    repeat (3) @(negedge clk);
    compare("R11 reset");
    rst_n = 1'b1;
    idle(1, 3'b000, "R11 after reset");

    // R1/R2: five pushes to channel 1 with varied md/sz, fifth discarded
    for (int i = 0; i < 5; i++) step(1, mk(1, i % 4, (i * 3) % 8), 0, 0, 0, 0, 3'b000, "R1 R2 fill ch1");
    idle(6, 3'b001, "R2 drain ch1");

    // R3: fill channel 2, then push and pop together on a full queue
    for (int i = 0; i < 4; i++) step(1, mk(2, 3, 7), 0, 0, 0, 0, 3'b000, "R2 fill ch2");
    step(1, mk(2, 0, 0), 0, 0, 0, 0, 3'b010, "R3 push+pop full");
    idle(6, 3'b010, "R3 drain ch2");
    step(1, mk(3, 2, 6), 0, 0, 0, 0, 3'b000, "R1 ch3 ignores md sz");
    idle(2, 3'b100, "R1 drain ch3");

    // R4/R5: channel-0 handshake
    step(1, mk(0, 0, 0), 1, 0, 0, 0, 3'b000, "R4 busy ignored");
    step(1, mk(0, 0, 4), 0, 0, 0, 0, 3'b000, "R4 accepted");
    step(0, '0, 0, 1, 0, 0, 3'b000, "R5 take");
    step(1, mk(0, 0, 7), 0, 1, 0, 0, 3'b000, "R5 accept beats take");
    step(0, '0, 0, 1, 0, 0, 3'b000, "R5 take again");

    // R6/R7: enable and stop
    step(0, '0, 0, 0, 1, 0, 3'b000, "R7 cpu set");
    step(1, mk(0, 1, 7), 1, 0, 0, 0, 3'b000, "R6 stop refused busy");
    step(1, mk(0, 3, 7), 0, 0, 0, 0, 3'b000, "R6 stop accepted");
    step(1, mk(0, 0, 0), 0, 0, 0, 0, 3'b000, "R7 words cannot set");
    step(0, '0, 0, 0, 1, 0, 3'b000, "R7 cpu set again");
    step(1, mk(0, 2, 7), 0, 0, 1, 0, 3'b000, "R7 set beats stop");

    // R10: no-operation encodings
    step(1, mk(0, 0, 5), 0, 0, 0, 0, 3'b000, "R10 md0 sz5");
    step(1, mk(0, 0, 6), 0, 0, 0, 0, 3'b000, "R10 md0 sz6");
    step(1, mk(0, 1, 6), 0, 0, 0, 0, 3'b000, "R10 md1 sz6");
    step(1, mk(0, 3, 0), 0, 0, 0, 0, 3'b000, "R10 md3 sz0");

    // R8/R9: flush with queues and pending request loaded
    for (int i = 0; i < 3; i++) step(1, mk(i + 1, 0, 0), 0, 0, 0, 0, 3'b000, "R8 load");
    step(1, mk(0, 0, 1), 0, 0, 0, 0, 3'b000, "R8 load ch0");
    step(1, mk(0, 2, 6), 1, 1, 0, 1, 3'b111, "R8 R9 flush with freeze");
    step(1, mk(1, 0, 0), 0, 0, 0, 0, 3'b000, "R8 after flush");
    step(1, mk(0, 2, 6), 0, 0, 0, 0, 3'b111, "R9 flush without freeze");
    idle(2, 3'b000, "R8 settle");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom_range(0, 99));
      logic [6:0] w = 7'($urandom);
      if (r < 5) w = mk(0, 2, 6);
      else if (r < 12) w = mk(0, 1 + int'($urandom_range(0, 2)), 7);
      step($urandom_range(0, 3) != 0, w, $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
           $urandom_range(0, 9) == 0, 1'($urandom), 3'($urandom), "random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule